// File: doc/BRIEF.md
# Multimode 64-bit Timer with Watchdog

The block is a counter pair made of two 32-bit halves that software configures through a small register port. It can run as one 64-bit counter, as two 32-bit counters that run on their own, as a chained pair in which the lower half divides the input rate for the upper half, or as a watchdog. Each counter counts up to its period value and then wraps to zero. The wrap raises a status bit, and it can also send an interrupt pulse and a DMA sync pulse. The lower half counts either every clock or on each rising edge of an external count input. A second input can snapshot the counter pair into capture registers on a rising edge, a falling edge, or both.

Register addresses: 0 control, 1 lower count, 2 upper count, 3 lower period, 4 upper period, 5 lower capture, 6 upper capture, 7 status, 8 watchdog key. Control fields, counting from bit 0: mode[1:0] (0 wide, 1 dual, 2 chained, 3 watchdog), runLo[2], runHi[3], extClk[4], rdClr[5], capRise[6], capFall[7], irqEnLo[8], irqEnHi[9], dmaEn[10]. Status bits: 0 lower/wide wrap, 1 upper wrap, 2 capture. Writing a 1 to a status bit clears it. Read data is combinational from the address. A write takes effect at the next rising clock edge.

In watchdog mode the block counts the full 64-bit value once armed. Software services it by writing two key words in order. A wrong key, or a count that reaches the period, raises a sticky reset request.

Top module: `dual_half_timer`

## Requirements
- R1: After reset, control, counts, periods, captures and status read as 0, and irqLo, irqHi, dmaSync and wdRst are low. The register addresses and control bit positions are as listed above.
- R2: In wide mode (mode 0, runLo=1) the 64-bit pair advances by one per tick. The lower half carries into the upper half. When the pair equals {upper period, lower period}, the next tick loads zero.
- R3: In dual mode (mode 1) each half counts from 0 to its own period and wraps on its own. The lower half runs on runLo and the upper half on runHi, every clock. A lower wrap sets status bit 0 and an upper wrap sets status bit 1.
- R4: In chained mode (mode 2) the upper half advances only on the tick where the lower half wraps. Only an upper wrap sets a status bit (bit 1); lower wraps set none.
- R5: With extClk=1 the lower half ticks once per rising edge of tmrClkIn, however long the input stays high.
- R6: On the enabled edge of capEvIn (capRise, capFall, or both), the capture registers take the count held before that edge. The capture sets status bit 2 and pulses irqLo when irqEnLo=1. An edge that is not enabled leaves the capture registers unchanged.
- R7: With rdClr=1, reading the lower count (address 1) returns the current value and clears that half at the same edge; in wide mode it clears both halves. With rdClr=0 a read does not change the count.
- R8: A lower/wide wrap pulses irqLo for one cycle only when irqEnLo=1. An upper wrap pulses irqHi only when irqEnHi=1. Any wrap pulses dmaSync only when dmaEn=1. Status bits are set regardless of these enables, and writing 1 to a bit clears it.
- R9: Once armed, the watchdog is serviced by writing 32'hA5C30F01 and then 32'h5A3CF0FE to address 8. The second write clears the count, and wdRst stays low.
- R10: While armed, a key write out of order, or the count reaching the period, sets wdRst, and wdRst stays high until reset. Key writes made before arming have no effect.
- R11: A control write with mode 3 and runLo=1 arms the watchdog. After that, writes to control, period and count registers are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (used for read-clear) |
| regAddr | input | 4 | Register address |
| regWrData | input | HALF_W | Write data |
| regRdData | output | HALF_W | Read data for regAddr |
| tmrClkIn | input | 1 | External count input, rising edges counted |
| capEvIn | input | 1 | Capture event input |
| irqLo | output | 1 | Lower/wide wrap or capture interrupt pulse |
| irqHi | output | 1 | Upper wrap interrupt pulse |
| dmaSync | output | 1 | DMA sync pulse on a wrap |
| wdRst | output | 1 | Sticky watchdog reset request |

## Verification
Counts, status bits, interrupt pulses, captures and wdRst all change at the first rising edge at which the tick, event or write is seen. Read data is valid in the same cycle as the address, and a read-clear takes effect at the edge that ends the read cycle. A control write that stops the counter still lets one final tick count at its own edge. The bench drives and samples at falling edges. It derives every expected count from the number of rising edges since enable, including the edges consumed by its own register accesses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_ADDR_W = 4;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 4'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_CNT_LO = 4'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_CNT_HI = 4'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_PRD_LO = 4'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_PRD_HI = 4'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_CAP_LO = 4'd5;
  localparam logic [REG_ADDR_W-1:0] ADDR_CAP_HI = 4'd6;
  localparam logic [REG_ADDR_W-1:0] ADDR_STAT   = 4'd7;
  localparam logic [REG_ADDR_W-1:0] ADDR_KEY    = 4'd8;

  typedef enum logic [1:0] {
    MODE_WIDE  = 2'd0,
    MODE_DUAL  = 2'd1,
    MODE_CHAIN = 2'd2,
    MODE_WDOG  = 2'd3
  } tmrMode_e;

  // Control word, most significant field first.
  typedef struct packed {
    logic     dmaEn;
    logic     irqEnHi;
    logic     irqEnLo;
    logic     capFall;
    logic     capRise;
    logic     rdClr;
    logic     extClk;
    logic     runHi;
    logic     runLo;
    tmrMode_e mode;
  } ctrlReg_t;

  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic incLo;
    logic clrLo;
    logic incHi;
    logic clrHi;
    logic ldCntLo;
    logic ldCntHi;
    logic ldPrdLo;
    logic ldPrdHi;
    logic capture;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        stb,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] cntLo,
  output logic [HALF_W-1:0] cntHi,
  output logic [HALF_W-1:0] prdLo,
  output logic [HALF_W-1:0] prdHi,
  output logic [HALF_W-1:0] capLo,
  output logic [HALF_W-1:0] capHi,
  output logic              loAtPrd,
  output logic              hiAtPrd,
  output logic              wideAtPrd,
  output logic              loAllOnes
);
  localparam int NUM_HALF = 2;

  logic [NUM_HALF-1:0] incV, clrV, ldCntV, ldPrdV;
  logic [NUM_HALF-1:0][HALF_W-1:0] cntAll, prdAll, capAll;

  assign incV   = {stb.incHi, stb.incLo};
  assign clrV   = {stb.clrHi, stb.clrLo};
  assign ldCntV = {stb.ldCntHi, stb.ldCntLo};
  assign ldPrdV = {stb.ldPrdHi, stb.ldPrdLo};

  for (genvar g = 0; g < NUM_HALF; g++) begin : halfG
    logic [HALF_W-1:0] cntQ, prdQ, capQ;

    // Clear beats a software load, which beats an increment.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (clrV[g]) begin
        cntQ <= '0;
      end else if (ldCntV[g]) begin
        cntQ <= wrData;
      end else if (incV[g]) begin
        cntQ <= cntQ + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prdQ <= '0;
      end else if (ldPrdV[g]) begin
        prdQ <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capQ <= '0;
      end else if (stb.capture) begin
        capQ <= cntQ;
      end
    end

    assign cntAll[g] = cntQ;
    assign prdAll[g] = prdQ;
    assign capAll[g] = capQ;
  end

  assign cntLo = cntAll[0];
  assign cntHi = cntAll[1];
  assign prdLo = prdAll[0];
  assign prdHi = prdAll[1];
  assign capLo = capAll[0];
  assign capHi = capAll[1];

  assign loAtPrd   = (cntAll[0] == prdAll[0]);
  assign hiAtPrd   = (cntAll[1] == prdAll[1]);
  assign wideAtPrd = loAtPrd && hiAtPrd;
  assign loAllOnes = &cntAll[0];
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int                HALF_W = 32,
  parameter logic [HALF_W-1:0] KEY_A  = 32'hA5C3_0F01,
  parameter logic [HALF_W-1:0] KEY_B  = 32'h5A3C_F0FE
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [HALF_W-1:0]     regWrData,
  output logic [HALF_W-1:0]     regRdData,
  input  logic                  tmrClkIn,
  input  logic                  capEvIn,
  input  logic [HALF_W-1:0]     cntLo,
  input  logic [HALF_W-1:0]     cntHi,
  input  logic [HALF_W-1:0]     prdLo,
  input  logic [HALF_W-1:0]     prdHi,
  input  logic [HALF_W-1:0]     capLo,
  input  logic [HALF_W-1:0]     capHi,
  input  logic                  loAtPrd,
  input  logic                  hiAtPrd,
  input  logic                  wideAtPrd,
  input  logic                  loAllOnes,
  output tmrStrobe_t            stb,
  output ctrlReg_t              ctrlQ,
  output logic [2:0]            statusQ,
  output logic                  wdArmed,
  output logic                  irqLo,
  output logic                  irqHi,
  output logic                  dmaSync,
  output logic                  wdRst
);
  localparam int CTRL_W = $bits(ctrlReg_t);
  localparam int STAT_W = 3;

  logic clkPrev, capPrev;
  logic clkRise, capRise, capFall;
  logic tickLo, tickHi, isWide;
  logic evLo, evHi, timeout;
  logic keyStage, keyWr, wdService, wrongKey;
  logic wrCtrl, wrStat;
  logic [STAT_W-1:0] statSet, statClr;
  ctrlReg_t newCtrl;

  // Edge detection on the two event inputs.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      capPrev <= 1'b0;
    end else begin
      clkPrev <= tmrClkIn;
      capPrev <= capEvIn;
    end
  end
  assign clkRise = tmrClkIn && !clkPrev;
  assign capRise = capEvIn && !capPrev;
  assign capFall = !capEvIn && capPrev;

  assign wrCtrl  = regWrEn && (regAddr == ADDR_CTRL);
  assign wrStat  = regWrEn && (regAddr == ADDR_STAT);
  assign newCtrl = ctrlReg_t'(regWrData[CTRL_W-1:0]);
  assign isWide  = (ctrlQ.mode == MODE_WIDE) || (ctrlQ.mode == MODE_WDOG);
  assign tickLo  = ctrlQ.runLo && (ctrlQ.extClk ? clkRise : 1'b1);

  // Watchdog key sequence.
  assign keyWr     = regWrEn && (regAddr == ADDR_KEY) && wdArmed;
  assign wdService = keyWr && keyStage && (regWrData == KEY_B);
  assign wrongKey  = keyWr && !((!keyStage && (regWrData == KEY_A)) ||
                                (keyStage && (regWrData == KEY_B)));

  always_comb begin
    stb     = '0;
    evLo    = 1'b0;
    evHi    = 1'b0;
    timeout = 1'b0;
    tickHi  = 1'b0;
    if (isWide) begin
      if (tickLo) begin
        if (wideAtPrd) begin
          stb.clrLo = 1'b1;
          stb.clrHi = 1'b1;
          if (ctrlQ.mode == MODE_WDOG) timeout = 1'b1;
          else                         evLo    = 1'b1;
        end else begin
          stb.incLo = 1'b1;
          stb.incHi = loAllOnes;
        end
      end
    end else begin
      if (tickLo) begin
        if (loAtPrd) begin
          stb.clrLo = 1'b1;
          evLo      = (ctrlQ.mode == MODE_DUAL);
        end else begin
          stb.incLo = 1'b1;
        end
      end
      tickHi = (ctrlQ.mode == MODE_DUAL) ? ctrlQ.runHi : (tickLo && loAtPrd);
      if (tickHi) begin
        if (hiAtPrd) begin
          stb.clrHi = 1'b1;
          evHi      = 1'b1;
        end else begin
          stb.incHi = 1'b1;
        end
      end
    end
    // Read-clear of the count.
    if (regRdEn && ctrlQ.rdClr && (regAddr == ADDR_CNT_LO)) begin
      stb.clrLo = 1'b1;
      if (isWide) stb.clrHi = 1'b1;
    end
    if (regRdEn && ctrlQ.rdClr && !isWide && (regAddr == ADDR_CNT_HI)) begin
      stb.clrHi = 1'b1;
    end
    if (wdService) begin
      stb.clrLo = 1'b1;
      stb.clrHi = 1'b1;
    end
    stb.ldCntLo = regWrEn && !wdArmed && (regAddr == ADDR_CNT_LO);
    stb.ldCntHi = regWrEn && !wdArmed && (regAddr == ADDR_CNT_HI);
    stb.ldPrdLo = regWrEn && !wdArmed && (regAddr == ADDR_PRD_LO);
    stb.ldPrdHi = regWrEn && !wdArmed && (regAddr == ADDR_PRD_HI);
    stb.capture = (ctrlQ.capRise && capRise) || (ctrlQ.capFall && capFall);
  end

  assign statSet = {stb.capture, evHi, evLo};
  assign statClr = wrStat ? regWrData[STAT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      wdArmed  <= 1'b0;
      keyStage <= 1'b0;
      wdRst    <= 1'b0;
      statusQ  <= '0;
      irqLo    <= 1'b0;
      irqHi    <= 1'b0;
      dmaSync  <= 1'b0;
    end else begin
      if (wrCtrl && !wdArmed) begin
        ctrlQ <= newCtrl;
        if (newCtrl.mode == MODE_WDOG && newCtrl.runLo) wdArmed <= 1'b1;
      end
      if (keyWr) keyStage <= !keyStage && (regWrData == KEY_A);
      wdRst   <= wdRst || timeout || wrongKey;
      statusQ <= (statusQ & ~statClr) | statSet;
      irqLo   <= ctrlQ.irqEnLo && (evLo || stb.capture);
      irqHi   <= ctrlQ.irqEnHi && evHi;
      dmaSync <= ctrlQ.dmaEn && (evLo || evHi);
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL:   regRdData[CTRL_W-1:0] = ctrlQ;
      ADDR_CNT_LO: regRdData = cntLo;
      ADDR_CNT_HI: regRdData = cntHi;
      ADDR_PRD_LO: regRdData = prdLo;
      ADDR_PRD_HI: regRdData = prdHi;
      ADDR_CAP_LO: regRdData = capLo;
      ADDR_CAP_HI: regRdData = capHi;
      ADDR_STAT:   regRdData[STAT_W-1:0] = statusQ;
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: rtl/dual_half_timer.sv
module dual_half_timer
  import tmr_pkg::*;
#(
  parameter int                HALF_W = 32,
  parameter logic [HALF_W-1:0] KEY_A  = 32'hA5C3_0F01,
  parameter logic [HALF_W-1:0] KEY_B  = 32'h5A3C_F0FE
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [HALF_W-1:0]     regWrData,
  output logic [HALF_W-1:0]     regRdData,
  input  logic                  tmrClkIn,
  input  logic                  capEvIn,
  output logic                  irqLo,
  output logic                  irqHi,
  output logic                  dmaSync,
  output logic                  wdRst
);
  tmrStrobe_t        stb;
  ctrlReg_t          ctrlQ;
  logic [2:0]        statusQ;
  logic              wdArmed;
  logic [HALF_W-1:0] cntLo, cntHi, prdLo, prdHi, capLo, capHi;
  logic              loAtPrd, hiAtPrd, wideAtPrd, loAllOnes;

  tmr_ctrl #(.HALF_W(HALF_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .tmrClkIn  (tmrClkIn),
    .capEvIn   (capEvIn),
    .cntLo     (cntLo),
    .cntHi     (cntHi),
    .prdLo     (prdLo),
    .prdHi     (prdHi),
    .capLo     (capLo),
    .capHi     (capHi),
    .loAtPrd   (loAtPrd),
    .hiAtPrd   (hiAtPrd),
    .wideAtPrd (wideAtPrd),
    .loAllOnes (loAllOnes),
    .stb       (stb),
    .ctrlQ     (ctrlQ),
    .statusQ   (statusQ),
    .wdArmed   (wdArmed),
    .irqLo     (irqLo),
    .irqHi     (irqHi),
    .dmaSync   (dmaSync),
    .wdRst     (wdRst)
  );

  tmr_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (regWrData),
    .cntLo     (cntLo),
    .cntHi     (cntHi),
    .prdLo     (prdLo),
    .prdHi     (prdHi),
    .capLo     (capLo),
    .capHi     (capHi),
    .loAtPrd   (loAtPrd),
    .hiAtPrd   (hiAtPrd),
    .wideAtPrd (wideAtPrd),
    .loAllOnes (loAllOnes)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  irqLo,
  input logic                  dmaSync,
  input logic                  wdRst,
  input logic                  wdArmed,
  input logic                  regRdEn,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic [HALF_W-1:0]     cntLo,
  input logic                  rdClr,
  input logic                  dmaEn,
  input logic [2:0]            statusQ
);
  // R8: an interrupt pulse always comes with its status bit set
  a_r8_irq_has_status: assert property (@(posedge clk) disable iff (!rstN)
    irqLo |-> (statusQ[0] || statusQ[2]));

  // R8: a sync pulse needs the enable in the cycle that produced it
  a_r8_dma_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    dmaSync |-> $past(dmaEn));

  // R7: a read-clear read leaves the lower count at zero
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && rdClr && (regAddr == ADDR_CNT_LO)) |=> (cntLo == '0));

  // R10: the reset request holds until reset
  a_r10_wdrst_sticky: assert property (@(posedge clk) disable iff (!rstN)
    wdRst |=> wdRst);

  // R10: the reset request only rises while armed
  a_r10_rst_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdRst) |-> $past(wdArmed));

  // R11: arming cannot be undone
  a_r11_arm_sticky: assert property (@(posedge clk) disable iff (!rstN)
    wdArmed |=> wdArmed);
endmodule

bind dual_half_timer tmr_checker #(.HALF_W(HALF_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .irqLo   (irqLo),
  .dmaSync (dmaSync),
  .wdRst   (wdRst),
  .wdArmed (wdArmed),
  .regRdEn (regRdEn),
  .regAddr (regAddr),
  .cntLo   (cntLo),
  .rdClr   (ctrlQ.rdClr),
  .dmaEn   (ctrlQ.dmaEn),
  .statusQ (statusQ)
);

// File: tb/sim_dual_half_timer.sv
module sim_dual_half_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY_A = 32'hA5C3_0F01;
  localparam logic [31:0] KEY_B = 32'h5A3C_F0FE;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        tmrClkIn = 1'b0, capEvIn = 1'b0;
  logic        irqLo, irqHi, dmaSync, wdRst;
  int          nVec = 0, nBad = 0;

  dual_half_timer u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .tmrClkIn(tmrClkIn), .capEvIn(capEvIn), .irqLo(irqLo), .irqHi(irqHi),
    .dmaSync(dmaSync), .wdRst(wdRst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mkCtrl(input logic [1:0] mode, input logic runLo,
      input logic runHi, input logic ext, input logic rdc, input logic cr,
      input logic cf, input logic ieLo, input logic ieHi, input logic dma);
    return {21'd0, dma, ieHi, ieLo, cf, cr, rdc, ext, runHi, runLo, mode};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; tmrClkIn = 1'b0; capEvIn = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic clearAll(input logic [31:0] pLo, input logic [31:0] pHi);
    wr(4'd0, 32'd0);
    wr(4'd3, pLo); wr(4'd4, pHi);
    wr(4'd1, 32'd0); wr(4'd2, 32'd0);
    wr(4'd7, 32'h7);
  endtask

  task automatic testReset();
    logic [31:0] d;
    rd(4'd0, d); chk("R1 ctrl after reset", d, 0);
    rd(4'd1, d); chk("R1 count after reset", d, 0);
    rd(4'd7, d); chk("R1 status after reset", d, 0);
    chk("R1 outputs after reset", {irqLo, irqHi, dmaSync, wdRst}, 0);
  endtask

  task automatic testWide();
    logic [31:0] d;
    clearAll(32'd5, 32'd0);
    wr(4'd0, mkCtrl(2'd0, 1, 0, 0, 0, 0, 0, 1, 0, 1));
    step(4);
    rd(4'd1, d); chk("R2 wide count 4 ticks", d, 4);
    chk("R8 no irq before wrap", irqLo, 0);
    step(1);
    chk("R8 irqLo on wrap", irqLo, 1);
    chk("R8 dmaSync on wrap", dmaSync, 1);
    rd(4'd1, d); chk("R2 wide wrapped to zero", d, 0);
    chk("R8 irqLo single cycle", irqLo, 0);
    wr(4'd0, 32'd0);
    rd(4'd7, d); chk("R8 status bit0 set", d, 1);
    wr(4'd7, 32'h1);
    rd(4'd7, d); chk("R8 status write-1 clear", d, 0);
    // no irq when disabled
    wr(4'd1, 32'd0);
    wr(4'd0, mkCtrl(2'd0, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    step(6);
    chk("R8 irq masked on wrap", {irqLo, dmaSync}, 0);
    rd(4'd7, d); chk("R8 status set while masked", d, 1);
    // carry into the upper half
    wr(4'd0, 32'd0);
    wr(4'd3, 32'hFFFF_FFFF); wr(4'd4, 32'd1);
    wr(4'd1, 32'hFFFF_FFFE); wr(4'd2, 32'd0);
    wr(4'd0, mkCtrl(2'd0, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    step(1);
    wr(4'd0, 32'd0);
    rd(4'd1, d); chk("R2 carry lower", d, 0);
    rd(4'd2, d); chk("R2 carry upper", d, 1);
  endtask

  task automatic testDual();
    logic [31:0] d;
    clearAll(32'd3, 32'd6);
    wr(4'd0, mkCtrl(2'd1, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    step(9);
    wr(4'd0, 32'd0);
    rd(4'd1, d); chk("R3 dual lower count", d, 2);
    rd(4'd2, d); chk("R3 dual upper count", d, 3);
    rd(4'd7, d); chk("R3 dual status both", d, 3);
    clearAll(32'd3, 32'd6);
    wr(4'd0, mkCtrl(2'd1, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    step(4);
    wr(4'd0, 32'd0);
    rd(4'd1, d); chk("R3 lower alone", d, 1);
    rd(4'd2, d); chk("R3 upper idle", d, 0);
    rd(4'd7, d); chk("R3 only bit0", d, 1);
  endtask

  task automatic testChain();
    logic [31:0] d;
    clearAll(32'd2, 32'd100);
    wr(4'd0, mkCtrl(2'd2, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    step(9);
    wr(4'd0, 32'd0);
    rd(4'd1, d); chk("R4 chained lower", d, 1);
    rd(4'd2, d); chk("R4 chained upper", d, 3);
    rd(4'd7, d); chk("R4 lower wraps silent", d, 0);
    clearAll(32'd2, 32'd1);
    wr(4'd0, mkCtrl(2'd2, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    step(6);
    wr(4'd0, 32'd0);
    rd(4'd1, d); chk("R4 chained lower 2", d, 1);
    rd(4'd2, d); chk("R4 upper wrapped", d, 0);
    rd(4'd7, d); chk("R4 upper wrap status", d, 2);
  endtask

  task automatic testExt();
    logic [31:0] d;
    clearAll(32'd1000, 32'd0);
    wr(4'd0, mkCtrl(2'd1, 1, 0, 1, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 3; i++) begin
      tmrClkIn = 1'b1; step(3);
      tmrClkIn = 1'b0; step(2);
    end
    wr(4'd0, 32'd0);
    rd(4'd1, d); chk("R5 external edges counted", d, 3);
  endtask

  task automatic testCapture();
    logic [31:0] d;
    clearAll(32'd1000, 32'd0);
    wr(4'd0, mkCtrl(2'd1, 1, 0, 0, 0, 1, 0, 1, 0, 0));
    step(4);
    capEvIn = 1'b1; step(1);
    chk("R6 capture irq", irqLo, 1);
    capEvIn = 1'b0; step(2);
    wr(4'd0, 32'd0);
    rd(4'd5, d); chk("R6 rise capture value", d, 4);
    rd(4'd6, d); chk("R6 capture upper", d, 0);
    rd(4'd7, d); chk("R6 capture status", d, 4);
    wr(4'd0, mkCtrl(2'd1, 0, 0, 0, 0, 0, 1, 0, 0, 0));
    wr(4'd1, 32'd77);
    capEvIn = 1'b1; step(2);
    rd(4'd5, d); chk("R6 rise ignored in fall mode", d, 4);
    capEvIn = 1'b0; step(1);
    rd(4'd5, d); chk("R6 fall capture value", d, 77);
  endtask

  task automatic testReadClear();
    logic [31:0] d;
    clearAll(32'd1000, 32'd0);
    wr(4'd0, mkCtrl(2'd1, 1, 0, 0, 1, 0, 0, 0, 0, 0));
    step(5);
    rd(4'd1, d); chk("R7 read returns value", d, 5);
    step(2);
    rd(4'd1, d); chk("R7 count restarted", d, 2);
    wr(4'd0, mkCtrl(2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    rd(4'd1, d); chk("R7 plain read value", d, 1);
    rd(4'd1, d); chk("R7 plain read keeps count", d, 1);
  endtask

  task automatic testWatchdog();
    logic [31:0] d;
    doReset();
    wr(4'd8, 32'h1234_5678);
    chk("R10 key before arming ignored", wdRst, 0);
    wr(4'd3, 32'd20); wr(4'd4, 32'd0);
    wr(4'd0, mkCtrl(2'd3, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    step(10);
    wr(4'd8, KEY_A); wr(4'd8, KEY_B);
    step(15);
    chk("R9 serviced no reset", wdRst, 0);
    rd(4'd1, d); chk("R9 service cleared count", d, 15);
    wr(4'd8, KEY_A); wr(4'd8, KEY_B);
    wr(4'd0, 32'd0);
    wr(4'd3, 32'd1000);
    rd(4'd0, d);
    chk("R11 ctrl locked", d, mkCtrl(2'd3, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    step(16);
    chk("R10 no reset before period", wdRst, 0);
    step(1);
    chk("R11 period write ignored", wdRst, 0);
    step(1);
    chk("R10 timeout reset", wdRst, 1);
    step(3);
    chk("R10 reset sticky", wdRst, 1);
    doReset();
    wr(4'd3, 32'd20);
    wr(4'd0, mkCtrl(2'd3, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    step(1);
    chk("R10 armed quiet", wdRst, 0);
    wr(4'd8, KEY_B);
    chk("R10 wrong key reset", wdRst, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    testReset();
    testWide();
    testDual();
    testChain();
    testExt();
    testCapture();
    testReadClear();
    testWatchdog();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule